// File: doc/BRIEF.md
# Memory ECC Error Logging Register

This block sits beside a memory controller's ECC checker and keeps a record of the first memory error it reports. The checker supplies a one-cycle pulse for each corrected (single-bit) and uncorrectable (multi-bit) error, together with the physical address of the access and the 8-bit syndrome. The block stores the upper part of that address, the syndrome and a sticky flag for the error type. It then ignores all later errors until software clears the flags.

Software uses a plain 32-bit register port. A write takes effect at the next clock edge, and the register contents can always be read on `rd_data_o`. Three bits of the register are controls. One turns off the automatic scrub write-back. One routes a logged single-bit error to a non-maskable interrupt line. One routes a logged multi-bit error to a bus-error line. When a corrected error is logged and scrubbing is allowed, the block issues a one-cycle scrub request carrying the failing address, so the memory controller can write back the corrected data.

Top module: `ecc_err_log`

## Requirements
- R1: After synchronous reset every bit of `rd_data_o` is 0, and `nmi_o`, `bus_err_o` and `scrub_req_o` are low.
- R2: Bits 31 (scrub disable), 3 (bus-error enable) and 2 (NMI enable) take the value written on `wr_data_i` when `wr_en_i` is high. Written values in bits 30:4 have no effect on the register.
- R3: A single-bit error logged while both flags are clear sets bit 0. It loads bits 30:12 with address bits 31:13 and bits 11:4 with the syndrome. All three are visible on the edge that samples the pulse.
- R4: A multi-bit error logged while both flags are clear sets bit 1 and loads the address and syndrome fields in the same way.
- R5: When both error pulses arrive in the same cycle with the flags clear, only bit 1 (multi-bit) is set. The address and syndrome of that cycle are stored.
- R6: While bit 0 or bit 1 is set, later error pulses of either type change neither the flags nor the address and syndrome fields.
- R7: A write with a 1 in bit 0 or bit 1 clears both flags. A write with 0 in both of those bits leaves the flags unchanged.
- R8: An error pulse that coincides with a flag-clearing write is logged as a fresh first error.
- R9: `nmi_o` is high exactly while bit 0 and bit 2 are both 1.
- R10: `bus_err_o` is high exactly while bit 1 and bit 3 are both 1.
- R11: A logged single-bit error with bit 31 at 0 produces a one-cycle `scrub_req_o` pulse in the cycle after the logging edge, with `scrub_addr_o` equal to the full failing address. A multi-bit error, an error ignored under R6, or bit 31 at 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register contents |
| sbe_i | input | 1 | Single-bit (corrected) error pulse |
| mbe_i | input | 1 | Multi-bit (uncorrectable) error pulse |
| err_addr_i | input | 32 | Physical address of the failing access |
| err_syn_i | input | 8 | ECC syndrome of the failing access |
| nmi_o | output | 1 | Non-maskable interrupt request |
| bus_err_o | output | 1 | Bus error indication |
| scrub_req_o | output | 1 | One-cycle scrub write-back request |
| scrub_addr_o | output | 32 | Address to scrub, valid with scrub_req_o |

## Verification
The hardest case to reach is a new error in the same cycle as a write that clears the flags. That write must coincide with a checker pulse while an older error is still logged. The bench aligns both on one negative clock edge after first logging an error. It then checks that the fresh address, syndrome and scrub pulse replace the old record. The freeze rule is exercised by following every logged error with a pulse of the opposite type and a different address, then confirming the register reads unchanged.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
  localparam int POS_SBE      = 0;
  localparam int POS_MBE      = 1;
  localparam int POS_NMI_EN   = 2;
  localparam int POS_BERR_EN  = 3;
  localparam int POS_SYN_LSB  = 4;

  typedef enum logic [1:0] {
    FLG_NONE = 2'b00,
    FLG_SBE  = 2'b01,
    FLG_MBE  = 2'b10
  } flag_e;
endpackage

// File: rtl/ecclog_ctrl.sv
module ecclog_ctrl #(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             scrub_dis_o,
  output logic             nmi_en_o,
  output logic             berr_en_o
);
  import ecclog_pkg::*;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      scrub_dis_o <= 1'b0;
      nmi_en_o    <= 1'b0;
      berr_en_o   <= 1'b0;
    end else if (wr_en_i) begin
      scrub_dis_o <= wr_data_i[REG_W-1];
      nmi_en_o    <= wr_data_i[POS_NMI_EN];
      berr_en_o   <= wr_data_i[POS_BERR_EN];
    end
  end

  // R2: control bits follow a write on the next edge
  a_r2_ctrl_load: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> (nmi_en_o == $past(wr_data_i[POS_NMI_EN])) &&
                (scrub_dis_o == $past(wr_data_i[REG_W-1])));
endmodule

// File: rtl/ecclog_capture.sv
module ecclog_capture #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int LOG_W  = 19
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic              clr_i,
  output ecclog_pkg::flag_e flags_o,
  output logic [LOG_W-1:0]  log_addr_o,
  output logic [SYN_W-1:0]  log_syn_o,
  output logic              take_sbe_o
);
  import ecclog_pkg::*;

  logic free, hit;

  assign free       = (flags_o == FLG_NONE) || clr_i;
  assign hit        = free && (sbe_i || mbe_i);
  assign take_sbe_o = hit && !mbe_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flags_o    <= FLG_NONE;
      log_addr_o <= '0;
      log_syn_o  <= '0;
    end else if (hit) begin
      flags_o    <= mbe_i ? FLG_MBE : FLG_SBE;
      log_addr_o <= addr_i[ADDR_W-1 -: LOG_W];
      log_syn_o  <= syn_i;
    end else if (clr_i) begin
      flags_o    <= FLG_NONE;
    end
  end

  // R3: single-bit error on a free log is recorded with its address
  a_r3_sbe_log: assert property (@(posedge clk_i) disable iff (rst_i)
    (free && sbe_i && !mbe_i) |=> (flags_o == FLG_SBE) &&
      (log_addr_o == $past(addr_i[ADDR_W-1 -: LOG_W])) && (log_syn_o == $past(syn_i)));

  // R5: multi-bit wins a tie
  a_r5_mbe_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    (free && mbe_i) |=> (flags_o == FLG_MBE));

  // R6: a held record is frozen
  a_r6_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    (flags_o != FLG_NONE && !clr_i) |=>
      $stable(flags_o) && $stable(log_addr_o) && $stable(log_syn_o));

  // R7: clear without a new error empties the flags
  a_r7_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !sbe_i && !mbe_i) |=> (flags_o == FLG_NONE));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int LOG_W  = 19
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  output logic              nmi_o,
  output logic              bus_err_o,
  output logic              scrub_req_o,
  output logic [ADDR_W-1:0] scrub_addr_o
);
  import ecclog_pkg::*;

  localparam int REG_W = 1 + LOG_W + SYN_W + 4;

  logic  scrub_dis, nmi_en, berr_en, clr, take_sbe;
  flag_e flags;
  logic [LOG_W-1:0] log_addr;
  logic [SYN_W-1:0] log_syn;

  assign clr = wr_en_i && (wr_data_i[POS_SBE] || wr_data_i[POS_MBE]);

  ecclog_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .scrub_dis_o(scrub_dis), .nmi_en_o(nmi_en), .berr_en_o(berr_en)
  );

  ecclog_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .LOG_W(LOG_W)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .sbe_i(sbe_i), .mbe_i(mbe_i),
    .addr_i(err_addr_i), .syn_i(err_syn_i), .clr_i(clr),
    .flags_o(flags), .log_addr_o(log_addr), .log_syn_o(log_syn),
    .take_sbe_o(take_sbe)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      scrub_req_o  <= 1'b0;
      scrub_addr_o <= '0;
    end else begin
      scrub_req_o <= take_sbe && !scrub_dis;
      if (take_sbe) scrub_addr_o <= err_addr_i;
    end
  end

  assign nmi_o     = flags[POS_SBE] && nmi_en;
  assign bus_err_o = flags[POS_MBE] && berr_en;
  assign rd_data_o = {scrub_dis, log_addr, log_syn, berr_en, nmi_en, flags};

  // R11: a scrub pulse only ever accompanies a single-bit record
  a_r11_scrub_sbe: assert property (@(posedge clk_i) disable iff (rst_i)
    scrub_req_o |-> (flags == FLG_SBE));

  // R10: bus error never without a multi-bit record
  a_r10_berr_src: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_err_o |-> rd_data_o[POS_MBE]);

  initial begin
    a_r2_width: assert (REG_W == 32);
  end
endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst, wr_en, sbe, mbe;
  logic [31:0] wr_data, rd_data, eaddr, scrub_addr;
  logic [7:0]  esyn;
  logic        nmi, berr, scrub;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ecc_err_log u0 (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .sbe_i(sbe), .mbe_i(mbe), .err_addr_i(eaddr),
    .err_syn_i(esyn), .nmi_o(nmi), .bus_err_o(berr),
    .scrub_req_o(scrub), .scrub_addr_o(scrub_addr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic dis, input logic [31:0] a,
      input logic [7:0] s, input logic be, input logic ne, input logic [1:0] f);
    return {dis, a[31:13], s, be, ne, f};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic err(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y);
    @(negedge clk); sbe = s; mbe = m; eaddr = a; esyn = y;
    @(negedge clk); sbe = 1'b0; mbe = 1'b0;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ctl, a0, a1;
    logic [7:0]  s0;
    rst = 1'b1; wr_en = 0; wr_data = 0; sbe = 0; mbe = 0; eaddr = 0; esyn = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reg", rd_data, 32'h0);
    chk("R1 outs", {29'd0, nmi, berr, scrub}, 32'h0);

    wr(32'hFFFF_FFFF);
    chk("R2 set", rd_data, 32'h8000_000C);
    wr(32'h7FFF_FFF0);
    chk("R2 ro", rd_data, 32'h0);

    // single-bit sweep over control settings
    for (int i = 0; i < 8; i++) begin
      ctl = {i[2], 27'd0, i[1], i[0], 2'b00};
      a0 = 32'h1357_9BDF * (i + 1) ^ (32'h1 << (i * 4));
      a1 = ~a0;
      s0 = 8'(8'h3C + i * 29);
      wr(ctl);
      @(negedge clk); sbe = 1; eaddr = a0; esyn = s0;
      @(negedge clk); sbe = 0;
      chk("R3 sbe log", rd_data, model(i[2], a0, s0, i[1], i[0], 2'b01));
      chk("R9 nmi", {31'd0, nmi}, {31'd0, i[0]});
      chk("R10 berr", {31'd0, berr}, 32'h0);
      chk("R11 pulse", {31'd0, scrub}, {31'd0, !i[2]});
      if (!i[2]) chk("R11 addr", scrub_addr, a0);
      @(negedge clk);
      chk("R11 one cycle", {31'd0, scrub}, 32'h0);
      err(1'b0, 1'b1, a1, ~s0);
      chk("R6 hold mbe", rd_data, model(i[2], a0, s0, i[1], i[0], 2'b01));
      err(1'b1, 1'b0, a1, ~s0);
      chk("R11 none frozen", {31'd0, scrub}, 32'h0);
      wr(ctl);
      chk("R7 zero write", rd_data, model(i[2], a0, s0, i[1], i[0], 2'b01));
      wr(ctl | (i[0] ? 32'h2 : 32'h1));
      chk("R7 clear", rd_data[1:0], 2'b00);
      chk("R9 nmi drop", {31'd0, nmi}, 32'h0);
    end

    // multi-bit sweep
    for (int i = 0; i < 4; i++) begin
      ctl = {27'd0, i[1], i[0], 2'b00};
      a0 = 32'hA5A5_0000 + i * 32'h0012_3457;
      s0 = 8'(8'h91 ^ i);
      wr(ctl);
      @(negedge clk); mbe = 1; eaddr = a0; esyn = s0;
      @(negedge clk); mbe = 0;
      chk("R4 mbe log", rd_data, model(1'b0, a0, s0, i[1], i[0], 2'b10));
      chk("R10 berr", {31'd0, berr}, {31'd0, i[1]});
      chk("R9 no nmi", {31'd0, nmi}, 32'h0);
      chk("R11 no scrub mbe", {31'd0, scrub}, 32'h0);
      err(1'b1, 1'b0, ~a0, 8'h00);
      chk("R6 hold sbe", rd_data, model(1'b0, a0, s0, i[1], i[0], 2'b10));
      wr(ctl | 32'h3);
      chk("R7 clear", rd_data[1:0], 2'b00);
    end

    // simultaneous pulses
    wr(32'h0000_000C);
    err(1'b1, 1'b1, 32'hDEAD_BEEF, 8'h5A);
    chk("R5 tie", rd_data, model(1'b0, 32'hDEAD_BEEF, 8'h5A, 1'b1, 1'b1, 2'b10));
    chk("R5 no scrub", {31'd0, scrub}, 32'h0);
    chk("R10 tie berr", {30'd0, nmi, berr}, 32'h1);

    // clear coinciding with a new single-bit error
    @(negedge clk); wr_en = 1; wr_data = 32'h0000_0006; sbe = 1; eaddr = 32'h0BAD_F00D; esyn = 8'hC3;
    @(negedge clk); wr_en = 0; wr_data = 0; sbe = 0;
    chk("R8 recapture", rd_data, model(1'b0, 32'h0BAD_F00D, 8'hC3, 1'b0, 1'b1, 2'b01));
    chk("R8 scrub", {31'd0, scrub}, 32'h1);
    chk("R8 scrub addr", scrub_addr, 32'h0BAD_F00D);

    // reset clears everything again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 rereset", rd_data, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule